// File: doc/BRIEF.md
# Banked Dual-Read CPU Register File

This block is the working register storage of a small 16-bit processor core. It holds four data registers (D0 to D3), two address registers (X0, X1), a frame-base register and a static-base register. It also holds a user stack pointer and an interrupt stack pointer. Two read ports and one write port reach these registers. Each access names a register code, an access size and, for byte accesses, a half select. D0 and D1 can be reached as 8-bit halves. Every register can be reached as a 16-bit word. D2:D0, D3:D1 and X1:X0 can be reached as 32-bit pairs.

The banked registers are D0 to D3, X0, X1 and the frame base. They exist twice, and a bank flag picks the copy that reads and writes use. The static base and both stack pointers are single copies shared by the two banks. A stack flag decides which stack pointer the generic stack-pointer code reaches.

Reads are combinational. A write lands on the rising clock edge. Instruction decode, arithmetic, the program counter and interrupt vectoring live outside the block.

Top module: `banked_regfile`

## Requirements
- R1: Synchronous reset (`rst` high at a rising edge) clears every register in both banks, the static base and both stack pointers to zero, so all reads return zero afterwards.
- R2: The register codes are 0–3 for D0–D3, 4 for X0, 5 for X1, 6 for the frame base, 7 for the static base and 8 for the stack pointer. Sizes are 0 for byte, 1 for word and 2 for pair. A word write to codes 0–8 is returned by a word read of the same code after the next rising edge. A word read returns the value zero-extended.
- R3: A byte read of code 0 or 1 returns the high half (`hi`=1) or the low half (`hi`=0) of the register in bits 7:0, with the upper bits zero.
- R4: A byte write to code 0 or 1 changes only the selected 8 bits and leaves the other half unchanged.
- R5: For pair accesses, code 0 means D2:D0, code 1 means D3:D1 and code 4 means X1:X0, with the first-named register in bits 31:16. A pair write updates both registers at the same edge. A pair read returns both halves from the current bank.
- R6: When `bank_sel` is 0, bank 0 holds D0–D3, X0, X1 and the frame base; when it is 1, bank 1 holds them. A write to one bank leaves the other unchanged.
- R7: The static base and both stack pointers are shared, so they read the same under either bank.
- R8: Code 8 reaches the user stack pointer when `stk_sel` is 0 and the interrupt stack pointer when it is 1. The stack pointer that is not selected is not written.
- R9: A read of the register being written in the same cycle returns the value from before the write.
- R10: A write with an unsupported combination has no effect, and a read with such a combination returns zero. Unsupported combinations are codes 9–15, size 3, a byte access to codes other than 0 and 1, and a pair access to codes other than 0, 1 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bank_sel | input | 1 | Bank flag for banked registers |
| stk_sel | input | 1 | Stack flag: 0 user, 1 interrupt |
| ra_sel | input | 4 | Read port A register code |
| ra_size | input | 2 | Read port A access size |
| ra_hi | input | 1 | Read port A byte half select |
| ra_data | output | 2*W | Read port A data |
| rb_sel | input | 4 | Read port B register code |
| rb_size | input | 2 | Read port B access size |
| rb_hi | input | 1 | Read port B byte half select |
| rb_data | output | 2*W | Read port B data |
| we | input | 1 | Write enable |
| wr_sel | input | 4 | Write register code |
| wr_size | input | 2 | Write access size |
| wr_hi | input | 1 | Write byte half select |
| wr_data | input | 2*W | Write data (byte in 7:0, word in W-1:0) |

## Verification
The bench builds the block with its default width, W = 16, so that each byte is half a word and each pair is 32 bits wide. At this width the byte-merge corner of R4 is reachable: one half is rewritten while the other half already holds a distinct non-zero pattern. The pair ordering of R5 is also reachable, because the upper and lower words carry recognisably different data. Bank isolation, stack routing and the old-value read of R9 are then driven as directed sequences after the table of vectors.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bank_sel,
  input  logic           stk_sel,
  input  logic [3:0]     ra_sel,
  input  logic [1:0]     ra_size,
  input  logic           ra_hi,
  output logic [2*W-1:0] ra_data,
  input  logic [3:0]     rb_sel,
  input  logic [1:0]     rb_size,
  input  logic           rb_hi,
  output logic [2*W-1:0] rb_data,
  input  logic           we,
  input  logic [3:0]     wr_sel,
  input  logic [1:0]     wr_size,
  input  logic           wr_hi,
  input  logic [2*W-1:0] wr_data
);
  localparam int H = W / 2;
  localparam int NB = 7;

  // slots 0..6 banked: D0 D1 D2 D3 X0 X1 FRM; slot 7 unused
  logic [W-1:0] bk [2][8];
  logic [W-1:0] stat, usp, isp;
  logic [W-1:0] view [16];

  always_comb begin
    for (int i = 0; i < 16; i++) view[i] = '0;
    for (int i = 0; i < NB; i++) view[i] = bk[bank_sel][i];
    view[7] = stat;
    view[8] = stk_sel ? isp : usp;
  end

  function automatic logic [2*W-1:0] pick(input logic [3:0] s, input logic [1:0] z,
                                          input logic h, input logic [W-1:0] lo,
                                          input logic [W-1:0] up);
    logic [2*W-1:0] r;
    r = '0;
    case (z)
      2'd0: if (s < 4'd2) r[H-1:0] = h ? lo[W-1:H] : lo[H-1:0];
      2'd1: if (s <= 4'd8) r[W-1:0] = lo;
      2'd2: if (s == 4'd0 || s == 4'd1 || s == 4'd4) r = {up, lo};
      default: r = '0;
    endcase
    return r;
  endfunction

  // pair partner: 0->2, 1->3, 4->5
  assign ra_data = pick(ra_sel, ra_size, ra_hi, view[ra_sel],
                        view[(ra_sel == 4'd4) ? 4'd5 : (ra_sel + 4'd2)]);
  assign rb_data = pick(rb_sel, rb_size, rb_hi, view[rb_sel],
                        view[(rb_sel == 4'd4) ? 4'd5 : (rb_sel + 4'd2)]);

  logic [2:0] ws;
  logic [2:0] wp;
  assign ws = wr_sel[2:0];
  assign wp = (wr_sel == 4'd4) ? 3'd5 : (ws + 3'd2);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < 8; i++) bk[b][i] <= '0;
      stat <= '0;
      usp  <= '0;
      isp  <= '0;
    end else if (we) begin
      case (wr_size)
        2'd0: if (wr_sel < 4'd2) begin
          if (wr_hi) bk[bank_sel][ws][W-1:H] <= wr_data[H-1:0];
          else       bk[bank_sel][ws][H-1:0] <= wr_data[H-1:0];
        end
        2'd1: begin
          if (wr_sel < 4'd7)       bk[bank_sel][ws] <= wr_data[W-1:0];
          else if (wr_sel == 4'd7) stat <= wr_data[W-1:0];
          else if (wr_sel == 4'd8) begin
            if (stk_sel) isp <= wr_data[W-1:0];
            else         usp <= wr_data[W-1:0];
          end
        end
        2'd2: if (wr_sel == 4'd0 || wr_sel == 4'd1 || wr_sel == 4'd4) begin
          bk[bank_sel][ws] <= wr_data[W-1:0];
          bk[bank_sel][wp] <= wr_data[2*W-1:W];
        end
        default: ;
      endcase
    end
  end

  // bank isolation
  for (genvar g = 0; g < NB; g++) begin : g_bank_chk
    assert_bank1_kept_R6: assert property (@(posedge clk) disable iff (rst)
      !bank_sel |=> $stable(bk[1][g]));
    assert_bank0_kept_R6: assert property (@(posedge clk) disable iff (rst)
      bank_sel |=> $stable(bk[0][g]));
  end

  assert_low_half_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (we && wr_size == 2'd0 && wr_sel == 4'd0 && wr_hi && !bank_sel)
    |=> bk[0][0][H-1:0] == $past(bk[0][0][H-1:0]));
  assert_high_half_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (we && wr_size == 2'd0 && wr_sel == 4'd1 && !wr_hi && !bank_sel)
    |=> bk[0][1][W-1:H] == $past(bk[0][1][W-1:H]));

  assert_pair_both_R5: assert property (@(posedge clk) disable iff (rst)
    (we && wr_size == 2'd2 && wr_sel == 4'd0 && !bank_sel)
    |=> bk[0][2] == $past(wr_data[2*W-1:W]) && bk[0][0] == $past(wr_data[W-1:0]));

  assert_isp_untouched_R8: assert property (@(posedge clk) disable iff (rst)
    !stk_sel |=> $stable(isp));
  assert_usp_untouched_R8: assert property (@(posedge clk) disable iff (rst)
    stk_sel |=> $stable(usp));

  assert_bad_code_noop_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_sel > 4'd8 || wr_size == 2'd3)
    |=> $stable(stat) && $stable(usp) && $stable(isp));
  assert_bad_code_reads_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (ra_sel > 4'd8) |-> ra_data == '0);
endmodule

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;
  localparam int W = 16;
  logic clk = 0, rst = 1, bank_sel = 0, stk_sel = 0;
  logic [3:0] ra_sel = 0, rb_sel = 0, wr_sel = 0;
  logic [1:0] ra_size = 1, rb_size = 1, wr_size = 1;
  logic ra_hi = 0, rb_hi = 0, wr_hi = 0, we = 0;
  logic [2*W-1:0] ra_data, rb_data, wr_data = 0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  banked_regfile #(.W(W)) dut (.*);

  typedef struct packed {
    logic [3:0] s; logic [1:0] z; logic h; logic [31:0] d;
    logic [3:0] rs; logic [1:0] rz; logic rh; logic [31:0] e;
  } vec_t;

  localparam vec_t VEC [13] = '{
    '{4'd0, 2'd1, 1'b0, 32'h1234,     4'd0, 2'd1, 1'b0, 32'h1234},     // R2
    '{4'd0, 2'd0, 1'b1, 32'hAB,       4'd0, 2'd1, 1'b0, 32'hAB34},     // R4
    '{4'd0, 2'd0, 1'b0, 32'hCD,       4'd0, 2'd0, 1'b1, 32'hAB},       // R3 R4
    '{4'd1, 2'd1, 1'b0, 32'h5678,     4'd1, 2'd0, 1'b0, 32'h78},       // R3
    '{4'd0, 2'd2, 1'b0, 32'h11112222, 4'd2, 2'd1, 1'b0, 32'h1111},     // R5
    '{4'd1, 2'd2, 1'b0, 32'h33334444, 4'd1, 2'd2, 1'b0, 32'h33334444}, // R5
    '{4'd4, 2'd2, 1'b0, 32'h55556666, 4'd5, 2'd1, 1'b0, 32'h5555},     // R5
    '{4'd6, 2'd1, 1'b0, 32'h7777,     4'd6, 2'd1, 1'b0, 32'h7777},     // R2
    '{4'd7, 2'd1, 1'b0, 32'h8888,     4'd7, 2'd1, 1'b0, 32'h8888},     // R2
    '{4'd8, 2'd1, 1'b0, 32'h9999,     4'd8, 2'd1, 1'b0, 32'h9999},     // R2 R8
    '{4'd2, 2'd0, 1'b1, 32'hEE,       4'd2, 2'd1, 1'b0, 32'h1111},     // R10
    '{4'd9, 2'd1, 1'b0, 32'hFFFF,     4'd9, 2'd1, 1'b0, 32'h0},        // R10
    '{4'd6, 2'd2, 1'b0, 32'hDEADBEEF, 4'd6, 2'd1, 1'b0, 32'h7777}      // R10
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [1:0] z, input logic h,
                    input logic [31:0] d);
    @(negedge clk);
    we = 1; wr_sel = s; wr_size = z; wr_hi = h; wr_data = d;
    @(posedge clk);
    #1 we = 0;
  endtask

  task automatic rd(input logic [3:0] s, input logic [1:0] z, input logic h);
    @(negedge clk);
    ra_sel = s; ra_size = z; ra_hi = h;
    #1;
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    rd(4'd0, 2'd2, 0); chk("R1 D2:D0", ra_data, 0);
    rd(4'd8, 2'd1, 0); chk("R1 SP", ra_data, 0);

    for (int i = 0; i < 13; i++) begin
      wr(VEC[i].s, VEC[i].z, VEC[i].h, VEC[i].d);
      rd(VEC[i].rs, VEC[i].rz, VEC[i].rh);
      chk($sformatf("R2/R3/R4/R5/R10 vector %0d", i), ra_data, VEC[i].e);
    end

    // R6 bank switching
    bank_sel = 1;
    rd(4'd0, 2'd1, 0); chk("R6 bank1 D0 empty", ra_data, 0);
    wr(4'd0, 2'd1, 0, 32'hA5A5);
    rd(4'd0, 2'd1, 0); chk("R6 bank1 D0", ra_data, 32'hA5A5);
    // R7 shared static base under bank 1
    rd(4'd7, 2'd1, 0); chk("R7 shared static", ra_data, 32'h8888);
    bank_sel = 0;
    rd(4'd0, 2'd1, 0); chk("R6 bank0 D0 kept", ra_data, 32'h2222);

    // R8 stack routing
    stk_sel = 1;
    rd(4'd8, 2'd1, 0); chk("R8 isp empty", ra_data, 0);
    wr(4'd8, 2'd1, 0, 32'h4242);
    rd(4'd8, 2'd1, 0); chk("R8 isp", ra_data, 32'h4242);
    stk_sel = 0;
    rd(4'd8, 2'd1, 0); chk("R8 usp kept", ra_data, 32'h9999);

    // R9 old value during write, checked on port B
    @(negedge clk);
    rb_sel = 4'd3; rb_size = 2'd1; rb_hi = 0;
    we = 1; wr_sel = 4'd3; wr_size = 2'd1; wr_hi = 0; wr_data = 32'h0BAD;
    #1 chk("R9 old value", rb_data, 32'h3333);
    @(posedge clk);
    #1 we = 0;
    chk("R9 new value after edge", rb_data, 32'h0BAD);

    // R1 reset again clears both banks
    @(negedge clk); rst = 1;
    @(posedge clk); #1 rst = 0;
    bank_sel = 1;
    rd(4'd0, 2'd1, 0); chk("R1 bank1 cleared", ra_data, 0);
    bank_sel = 0;
    rd(4'd7, 2'd1, 0); chk("R1 static cleared", ra_data, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule